// File: doc/BRIEF.md
# Streaming Command-to-Bus Master

This block carries out one decoded memory-mapped access at a time on a single-master WISHBONE bus. A command gives a start address, a byte count, a direction and an addressing mode. The block turns it into a series of single-word bus cycles. Each cycle is a separate CYC/STB assertion that ends on the slave's acknowledge.

For writes, each word comes from an input stream with a valid/ready handshake, and the bus waits while no word is offered. For reads, each acknowledged word is sent out on a one-cycle valid strobe. In range mode the address walks through memory word by word. In constant mode every word goes to the start address, which lets a host fill or drain a FIFO port through one location.

When the command ends, the block raises a one-cycle completion pulse with a failure flag. Failure means a slave reported an error, or a cycle went unanswered for longer than a programmable limit. Routing each cycle to the right slave is the job of the interconnect beyond this block.

Top module: `dma_wb_master`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `wb_cyc_o`, `wb_stb_o`, `wr_ready`, `rd_valid` and `done` are 0. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from then until the completion pulse has been given.
- R2: `cmd_len` is a byte count from 0 to 8192. The number of bus words is the byte count divided by 4 and rounded up. A count of 0 completes with success and produces no bus cycle.
- R3: With `cmd_const` = 0, word i (counting from 0) uses address `cmd_addr + 4*i`. With `cmd_const` = 1, every word uses `cmd_addr`.
- R4: Each word is one bus cycle. CYC and STB rise together and stay high, with address, write data and WE unchanged, until ACK or ERR arrives. SEL is 4'b1111 and WE is 1 for writes and 0 for reads. STB is low for at least one cycle between words.
- R5: In a write, `wr_ready` is high only while the block waits for the next word. A word taken on a `wr_valid`/`wr_ready` handshake appears on `wb_dat_o` with STB high in the next cycle. No bus cycle starts while no word is offered.
- R6: In a read, each ACK produces `rd_valid` high for one cycle, in the cycle after the ACK, with `rd_data` equal to the `wb_dat_i` that came with that ACK.
- R7: After the ACK of the last word, `done` is high for exactly one cycle in the next cycle, with `done_err` = 0.
- R8: When ERR arrives, no further word is attempted or taken from the write stream. `done` then rises in the next cycle with `done_err` = 1.
- R9: If a cycle has had STB high for `timeout_cycles` cycles with no ACK or ERR, STB drops, `done` rises in the next cycle with `done_err` = 1, and the rest of the command is dropped. A limit of 0 disables this abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_const | input | 1 | 1 = constant-address mode |
| cmd_addr | input | 32 | Start byte address |
| cmd_len | input | 14 | Byte count, 0 to 8192 |
| timeout_cycles | input | 16 | Unanswered-cycle limit, 0 = off |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word accepted this cycle |
| wr_data | input | 32 | Write word |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | 32 | Read word |
| done | output | 1 | Command complete pulse |
| done_err | output | 1 | Failure flag, valid with `done` |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | 32 | Bus byte address |
| wb_sel_o | output | 4 | Byte lanes |
| wb_dat_o | output | 32 | Bus write data |
| wb_dat_i | input | 32 | Bus read data |
| wb_ack_i | input | 1 | Slave acknowledge |
| wb_err_i | input | 1 | Slave error |

## Verification
Some properties are checked on every cycle:
- A pending cycle holds its address, data and WE until it is answered.
- A write handshake leads to a strobed cycle carrying that word.
- Each read acknowledge yields a read strobe.
- An error, or the unanswered-cycle limit counted independently, leads straight to a failing completion.
- A taken command lowers `cmd_ready`.

Other behaviour only shows across a whole scenario, which the bench replays against its slave model's log:
- the address sequence in each mode
- the word count for odd and zero byte counts, including the 8 KB case
- how many stream words an aborted write consumed
- the success of a cycle answered exactly at the limit

// File: rtl/dma_wb_pkg.sv
package dma_wb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_BUS  = 2'd2,
        ST_FIN  = 2'd3
    } dma_state_e;
endpackage

// File: rtl/dma_addr_seq.sv
// Word address register: loaded at command start, stepped after each acknowledged word
module dma_addr_seq #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    input  logic              hold,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d = load_addr;
        end else if (advance && !hold) begin
            addr_d = addr_q + ADDR_W'(STEP);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;
endmodule

// File: rtl/dma_beat_cnt.sv
// Remaining-word counter
module dma_beat_cnt #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                   cnt_d = load_val;
        else if (dec && cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dma_tmo_timer.sv
// Counts strobe cycles of the current bus cycle; expired marks the last allowed one
module dma_tmo_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (limit != '0) && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/dma_wb_master.sv
module dma_wb_master
    import dma_wb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 14,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic              cmd_const,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [TMO_W-1:0]  timeout_cycles,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              done_err,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [DATA_W/8-1:0] wb_sel_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack_i,
    input  logic              wb_err_i
);
    localparam int SEL_W   = DATA_W / 8;
    localparam int BYTE_SH = $clog2(SEL_W);
    localparam int CNT_W   = LEN_W + 1;

    typedef struct packed {
        dma_state_e        st;
        logic              write;
        logic              cst;
        logic [DATA_W-1:0] wdata;
        logic              rvld;
        logic [DATA_W-1:0] rdata;
        logic              fail;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             addr_load, addr_adv, cnt_load, beat_dec;
    logic             beat_last, tmo_expired, in_bus;
    logic [CNT_W-1:0] words;

    assign words  = CNT_W'(({1'b0, cmd_len} + CNT_W'(SEL_W - 1)) >> BYTE_SH);
    assign in_bus = (ctl_q.st == ST_BUS);

    dma_addr_seq #(.ADDR_W(ADDR_W), .STEP(SEL_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_load),
        .load_addr (cmd_addr),
        .advance   (addr_adv),
        .hold      (ctl_q.cst),
        .addr      (wb_adr_o)
    );

    dma_beat_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (words),
        .dec      (beat_dec),
        .last     (beat_last)
    );

    dma_tmo_timer #(.TMO_W(TMO_W)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_bus),
        .limit   (timeout_cycles),
        .expired (tmo_expired)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rvld = 1'b0;
        addr_load  = 1'b0;
        addr_adv   = 1'b0;
        cnt_load   = 1'b0;
        beat_dec   = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    ctl_d.write = cmd_write;
                    ctl_d.cst   = cmd_const;
                    ctl_d.fail  = 1'b0;
                    addr_load   = 1'b1;
                    cnt_load    = 1'b1;
                    ctl_d.st    = (words == '0) ? ST_FIN : ST_PREP;
                end
            end
            ST_PREP: begin
                if (!ctl_q.write) begin
                    ctl_d.st = ST_BUS;
                end else if (wr_valid) begin
                    ctl_d.wdata = wr_data;
                    ctl_d.st    = ST_BUS;
                end
            end
            ST_BUS: begin
                if (wb_err_i) begin
                    ctl_d.fail = 1'b1;
                    ctl_d.st   = ST_FIN;
                end else if (wb_ack_i) begin
                    if (!ctl_q.write) begin
                        ctl_d.rvld  = 1'b1;
                        ctl_d.rdata = wb_dat_i;
                    end
                    beat_dec = 1'b1;
                    addr_adv = 1'b1;
                    ctl_d.st = beat_last ? ST_FIN : ST_PREP;
                end else if (tmo_expired) begin
                    ctl_d.fail = 1'b1;
                    ctl_d.st   = ST_FIN;
                end
            end
            ST_FIN: begin
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, write: 1'b0, cst: 1'b0, wdata: '0,
                       rvld: 1'b0, rdata: '0, fail: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_ready = (ctl_q.st == ST_IDLE);
    assign wr_ready  = (ctl_q.st == ST_PREP) && ctl_q.write;
    assign rd_valid  = ctl_q.rvld;
    assign rd_data   = ctl_q.rdata;
    assign done      = (ctl_q.st == ST_FIN);
    assign done_err  = done && ctl_q.fail;
    assign wb_cyc_o  = in_bus;
    assign wb_stb_o  = in_bus;
    assign wb_we_o   = in_bus && ctl_q.write;
    assign wb_sel_o  = in_bus ? '1 : '0;
    assign wb_dat_o  = ctl_q.wdata;
endmodule

// File: rtl/dma_wb_master_chk.sv
module dma_wb_master_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TMO_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [DATA_W-1:0] wr_data,
    input logic [TMO_W-1:0]  timeout_cycles,
    input logic              done,
    input logic              done_err,
    input logic              rd_valid,
    input logic              wb_stb_o,
    input logic              wb_we_o,
    input logic [ADDR_W-1:0] wb_adr_o,
    input logic [DATA_W-1:0] wb_dat_o,
    input logic              wb_ack_i,
    input logic              wb_err_i
);
    // Independent count of unanswered strobe cycles in the current bus cycle
    logic [TMO_W:0] stall_q;
    logic           pending, below_limit, at_limit;

    always_ff @(posedge clk) begin
        if (!rst_n)                                  stall_q <= '0;
        else if (wb_stb_o && !wb_ack_i && !wb_err_i) stall_q <= stall_q + 1'b1;
        else                                         stall_q <= '0;
    end

    assign pending     = wb_stb_o && !wb_ack_i && !wb_err_i;
    assign below_limit = (timeout_cycles == '0) || ((stall_q + 1'b1) < {1'b0, timeout_cycles});
    assign at_limit    = (timeout_cycles != '0) && ((stall_q + 1'b1) == {1'b0, timeout_cycles});

    assert_cmd_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_ready);

    assert_cycle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pending && below_limit |=> wb_stb_o && $stable(wb_adr_o) && $stable(wb_dat_o) && $stable(wb_we_o));

    assert_wr_to_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready |=> wb_stb_o && wb_we_o && (wb_dat_o == $past(wr_data)));

    assert_read_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o && wb_ack_i && !wb_err_i && !wb_we_o |=> rd_valid);

    assert_err_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o && wb_err_i |=> done && done_err && !wb_stb_o);

    assert_timeout_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pending && at_limit |=> done && done_err && !wb_stb_o);
endmodule

bind dma_wb_master dma_wb_master_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TMO_W  (TMO_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_ready      (cmd_ready),
    .wr_valid       (wr_valid),
    .wr_ready       (wr_ready),
    .wr_data        (wr_data),
    .timeout_cycles (timeout_cycles),
    .done           (done),
    .done_err       (done_err),
    .rd_valid       (rd_valid),
    .wb_stb_o       (wb_stb_o),
    .wb_we_o        (wb_we_o),
    .wb_adr_o       (wb_adr_o),
    .wb_dat_o       (wb_dat_o),
    .wb_ack_i       (wb_ack_i),
    .wb_err_i       (wb_err_i)
);

// File: tb/dma_wb_master_tb.sv
`timescale 1ns/1ps
module dma_wb_master_tb;
    localparam int NONE = 99999;
    localparam int LOGN = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_const = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [13:0] cmd_len = '0;
    logic [15:0] timeout_cycles = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        cmd_ready, wr_ready, rd_valid, done, done_err;
    logic [31:0] rd_data;
    logic        wb_cyc_o, wb_stb_o, wb_we_o;
    logic [31:0] wb_adr_o, wb_dat_o;
    logic [3:0]  wb_sel_o;
    logic [31:0] s_dat = '0;
    logic        s_ack = 1'b0, s_err = 1'b0;

    always #4 clk = ~clk;

    dma_wb_master u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_const(cmd_const), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .timeout_cycles(timeout_cycles), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .done_err(done_err), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o),
        .wb_we_o(wb_we_o), .wb_adr_o(wb_adr_o), .wb_sel_o(wb_sel_o), .wb_dat_o(wb_dat_o),
        .wb_dat_i(s_dat), .wb_ack_i(s_ack), .wb_err_i(s_err)
    );

    // Scenario configuration, written only by the main sequence
    int  err_at = NONE, hang_at = NONE, lat_fixed = -1, src_n = 0;
    bit  all_valid = 1'b0;
    logic mon_clr = 1'b0;
    logic [31:0] src [LOGN];

    // Monitor state, written only by the always blocks
    int  s_idx = 0, wait_cnt = 0, cur_lat = 0, src_idx = 0, rd_n = 0;
    int  rises = 0, streak = 0, last_streak = 0, done_cnt = 0, busy_ready = 0;
    bit  done_err_seen = 1'b0;
    logic        prev_stb = 1'b0;
    logic [31:0] log_adr [LOGN];
    logic [31:0] log_dat [LOGN];
    logic        log_we  [LOGN];
    logic [3:0]  log_sel [LOGN];
    logic [31:0] rd_log  [LOGN];

    // Slave model: answers after a latency, errors or stays silent on chosen words
    always @(posedge clk) begin
        s_ack <= 1'b0;
        s_err <= 1'b0;
        if (mon_clr) begin
            s_idx    <= 0;
            wait_cnt <= 0;
            cur_lat  <= (lat_fixed >= 0) ? lat_fixed : int'($urandom_range(0, 3));
        end else if (wb_cyc_o && wb_stb_o && !s_ack && !s_err && s_idx != hang_at && s_idx < LOGN) begin
            if (wait_cnt >= cur_lat) begin
                log_adr[s_idx] <= wb_adr_o;
                log_dat[s_idx] <= wb_dat_o;
                log_we[s_idx]  <= wb_we_o;
                log_sel[s_idx] <= wb_sel_o;
                s_dat <= {wb_adr_o[15:0], 16'(s_idx)};
                if (s_idx == err_at) s_err <= 1'b1;
                else                 s_ack <= 1'b1;
                s_idx    <= s_idx + 1;
                wait_cnt <= 0;
                cur_lat  <= (lat_fixed >= 0) ? lat_fixed : int'($urandom_range(0, 3));
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    // Stream, strobe, read and completion monitors
    always @(posedge clk) begin
        if (mon_clr) begin
            src_idx <= 0; rd_n <= 0; rises <= 0; streak <= 0; last_streak <= 0;
            done_cnt <= 0; done_err_seen <= 1'b0; busy_ready <= 0; prev_stb <= 1'b0;
        end else begin
            if (wr_valid && wr_ready) src_idx <= src_idx + 1;
            if (rd_valid && rd_n < LOGN) begin
                rd_log[rd_n] <= rd_data;
                rd_n <= rd_n + 1;
            end
            if (wb_stb_o && !prev_stb) rises <= rises + 1;
            prev_stb <= wb_stb_o;
            if (wb_stb_o) streak <= streak + 1;
            else begin
                if (streak != 0) last_streak <= streak;
                streak <= 0;
            end
            if (done) begin
                done_cnt <= done_cnt + 1;
                done_err_seen <= done_err;
            end
            if (cmd_ready && wb_cyc_o) busy_ready <= busy_ready + 1;
        end
    end

    always @(negedge clk) begin
        wr_valid <= (src_idx < src_n) && (all_valid || ($urandom_range(0, 3) != 0));
        wr_data  <= (src_idx < src_n) ? src[src_idx] : 32'h0;
    end

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input bit cst, input int i);
        return cst ? base : base + 32'(4 * i);
    endfunction

    task automatic run_cmd(input bit wr, input bit cst, input logic [31:0] base, input int len,
                           input int e_at, input int h_at, input int lf, input int tmo,
                           input bit allv, input int exp_streak);
        int words, exp_resp, exp_rd, exp_src, bad_a, bad_c, bad_d, n;
        bit exp_fail;
        words = (len + 3) / 4;
        for (int i = 0; i < words; i++) src[i] = $urandom;
        src_n = wr ? words : 0;
        err_at = e_at; hang_at = h_at; lat_fixed = lf; all_valid = allv;
        timeout_cycles = 16'(tmo);
        @(negedge clk) mon_clr = 1'b1;
        @(negedge clk) mon_clr = 1'b0;
        chk("R1", "cmd_ready while idle", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_write = wr; cmd_const = cst; cmd_addr = base; cmd_len = 14'(len);
        @(negedge clk) cmd_valid = 1'b0;
        n = 0;
        while (done_cnt == 0 && n < 30000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);

        exp_fail = 1'b0; exp_resp = words; exp_src = words;
        if (e_at < words)      begin exp_fail = 1'b1; exp_resp = e_at + 1; exp_src = e_at + 1; end
        else if (h_at < words) begin exp_fail = 1'b1; exp_resp = h_at;     exp_src = h_at + 1; end
        exp_rd = (e_at < words) ? e_at : exp_resp;

        chk("R7", "completion pulses", done_cnt, 1);
        chk(exp_fail ? "R8/R9" : "R7", "failure flag", done_err_seen, exp_fail);
        chk("R1", "cmd_ready during bus cycle", busy_ready, 0);
        chk("R2", "answered words", s_idx, exp_resp);
        chk("R4", "strobe rises", rises, exp_resp + ((h_at < words && e_at >= words) ? 1 : 0));
        bad_a = 0; bad_c = 0; bad_d = 0;
        for (int i = 0; i < exp_resp; i++) begin
            if (log_adr[i] !== exp_addr(base, cst, i)) bad_a++;
            if (log_we[i] !== wr || log_sel[i] !== 4'hF) bad_c++;
            if (wr && log_dat[i] !== src[i]) bad_d++;
        end
        chk("R3", "address mismatches", bad_a, 0);
        chk("R4", "we/sel mismatches", bad_c, 0);
        if (wr) begin
            chk("R5", "write data mismatches", bad_d, 0);
            chk(exp_fail ? "R8" : "R5", "stream words consumed", src_idx, exp_src);
        end else begin
            bad_d = 0;
            for (int i = 0; i < exp_rd; i++)
                if (rd_log[i] !== {exp_addr(base, cst, i)[15:0], 16'(i)}) bad_d++;
            chk("R6", "read strobes", rd_n, exp_rd);
            chk("R6", "read data mismatches", bad_d, 0);
        end
        if (exp_streak > 0) chk("R9", "strobe cycles of last bus cycle", last_streak, exp_streak);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", "reset cmd_ready", cmd_ready, 1);
        chk("R1", "reset cyc", wb_cyc_o, 0);
        chk("R1", "reset done", done, 0);
        chk("R1", "reset wr_ready/rd_valid", {wr_ready, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_cmd(1, 0, 32'h0000_1000, 4,    NONE, NONE, -1, 20, 0, 0);  // single word write
        run_cmd(0, 0, 32'h0010_0000, 8192, NONE, NONE, -1, 20, 1, 0);  // R2 maximum size
        run_cmd(1, 1, 32'h0000_2004, 64,   NONE, NONE, -1, 20, 0, 0);  // R3 constant write
        run_cmd(0, 1, 32'h0000_2008, 5,    NONE, NONE, -1, 20, 0, 0);  // R2 round-up
        run_cmd(0, 0, 32'h0000_3000, 0,    NONE, NONE, -1, 20, 0, 0);  // R2 zero length
        run_cmd(1, 0, 32'h0000_4000, 40,   3,    NONE, -1, 20, 0, 0);  // R8 write error
        run_cmd(0, 0, 32'h0000_5000, 16,   0,    NONE, -1, 20, 0, 0);  // R8 read error first word
        run_cmd(1, 0, 32'h0000_6000, 32,   NONE, 2,    -1, 7,  1, 7);  // R9 write timeout
        run_cmd(0, 1, 32'h0000_7000, 12,   NONE, 0,    -1, 1,  0, 1);  // R9 limit of one
        run_cmd(0, 0, 32'h0000_8000, 8,    NONE, NONE, 1,  3,  0, 3);  // R9 answered at the limit
        run_cmd(1, 0, 32'h0000_9000, 8,    NONE, NONE, 10, 0,  1, 12); // R9 limit disabled

        for (int k = 0; k < 30; k++) begin
            int len, e;
            len = int'($urandom_range(0, 160));
            e   = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 40)) : NONE;
            run_cmd($urandom_range(0, 1), $urandom_range(0, 1),
                    {16'h0, 14'($urandom), 2'b00}, len, e, NONE, -1,
                    ($urandom_range(0, 1) != 0) ? 20 : 0, 0, 0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule